// File: doc/BRIEF.md
# I2C Target with Clock-Stretched Byte Buffers

This block is the target (slave) side of an I2C bus, seen by the rest of the chip as a small byte interface. A host loads one outgoing byte into a transmit holding register and collects incoming bytes from a receive holding register. Flags tell the host when an incoming byte is waiting, when the transmitter wants another byte, and when a START has appeared on the bus. The bus lines are open-drain: the block only pulls SCL or SDA low, or lets them go.

Flow control is done by clock stretching. If the host has not supplied a byte when the bus needs one, or has not taken the last received byte, the block holds SCL low. The master's clock then waits. A host write or read releases the clock within a few cycles. Both bus inputs pass through a two-flop synchronizer before START, STOP and clock edges are detected. The block compares the first byte after START with a 7-bit own address. The receive holding register shows that address byte, whether or not it matched, until a data byte replaces it.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset, both open-drain enables are 0 (lines released), and the receive flag, transmit request flag, match flag and START flag are 0. The receive register reads 0x00.
- R2: A START (SDA falling while SCL is high) sets the START flag. The flag then stays at 1 until the host pulses the clear input, which returns it to 0.
- R3: The 8-bit address byte (7-bit address in bits 7..1, read/write bit in bit 0) is copied into the receive register without setting the receive flag. When bits 7..1 equal the own address, the match flag goes to 1 and SDA is pulled low for the ninth (acknowledge) clock.
- R4: When bits 7..1 of the address byte differ from the own address, the match flag is 0 and SDA stays released in the acknowledge slot. The block then ignores all bus traffic: no acknowledge, receive register and receive flag unchanged until the next START.
- R5: In a matched write (bit 0 = 0), each data byte is placed in the receive register with the receive flag set, and SDA is pulled low for its acknowledge, provided the flag was 0. A host read pulse clears the flag.
- R6: If a data byte completes while the receive flag is still 1, SCL is held low from the falling edge after its eighth bit and the receive register keeps the old byte. After the host read, the new byte is loaded, the flag is set again, SCL is released and the byte is acknowledged.
- R7: In a matched read (bit 0 = 1), the transmit holding register is copied into the shifter at the falling edge that ends the address acknowledge. The byte is sent most significant bit first.
- R8: Each copy into the shifter sets the transmit request flag. A host write that is not consumed in the same cycle clears it. After a master acknowledge (SDA low in the ninth clock), the held byte is sent next.
- R9: If no byte is held when a copy is due, SCL is held low after the acknowledge clock. A host write then goes straight to the shifter and SCL is released. That byte is sent.
- R10: After a master non-acknowledge (SDA high in the ninth clock), SDA stays released for any further clocks until STOP or START.
- R11: A STOP (SDA rising while SCL is high) clears the match flag and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Own 7-bit target address |
| tx_wr_i | input | 1 | Host write strobe for the transmit byte |
| tx_data_i | input | 8 | Host transmit byte |
| rx_rd_i | input | 1 | Host read strobe, clears the receive flag |
| rx_data_o | output | 8 | Receive holding register |
| rx_full_o | output | 1 | Receive flag: unread byte present |
| tx_req_o | output | 1 | Transmit request flag |
| matched_o | output | 1 | Own address matched in this transfer |
| start_flag_o | output | 1 | START seen since last clear |
| start_clr_i | input | 1 | Clears the START flag |

## Verification
The bench targets the two stall points. In each it checks that SCL really stays low while the host waits, and that the stalled byte is the one delivered once the host acts. A design that released the clock early would lose or overwrite a byte, and one that never released it would hang the master. It also checks a non-matching address followed by more traffic. A design that kept listening would acknowledge it or overwrite the address in the receive register. Finally, it ends a read with a non-acknowledge while a zero byte is pending. A design that still shifted that byte out would pull SDA low during the master's extra clocks.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = $clog2(BYTE_W);

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX,
      ST_RX_STALL,
      ST_RX_ACK,
      ST_TX,
      ST_TX_STALL,
      ST_TX_ACK,
      ST_IGNORE
   } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   localparam int LINES = 2;

   logic [LINES-1:0] raw;
   logic [LINES-1:0] lvl;
   logic [LINES-1:0] lvl_q;

   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign lvl[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '1;
      else        lvl_q <= lvl;
   end

   // bit 1 is SCL, bit 0 is SDA
   assign sda_s_o    = lvl[0];
   assign scl_rise_o = lvl[1] & ~lvl_q[1];
   assign scl_fall_o = ~lvl[1] & lvl_q[1];
   assign start_o    = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
   assign stop_o     = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];
endmodule

// File: rtl/i2c_tgt_hostbuf.sv
module i2c_tgt_hostbuf
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_wr_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   input  logic              tx_take_i,
   output logic [BYTE_W-1:0] tx_hold_o,
   output logic              tx_full_o,
   output logic              tx_req_o,
   input  logic              rx_rd_i,
   input  logic              rx_load_i,
   input  logic              addr_load_i,
   input  logic [BYTE_W-1:0] rx_byte_i,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic              rx_full_o,
   input  logic              start_i,
   input  logic              start_clr_i,
   output logic              start_flag_o
);
   // transmit side: a write during a take that drained a full buffer refills it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold_o <= '0;
         tx_full_o <= 1'b0;
         tx_req_o  <= 1'b0;
      end else if (tx_take_i) begin
         if (tx_wr_i && tx_full_o) begin
            tx_hold_o <= tx_data_i;
            tx_full_o <= 1'b1;
            tx_req_o  <= 1'b0;
         end else begin
            tx_full_o <= 1'b0;
            tx_req_o  <= 1'b1;
         end
      end else if (tx_wr_i) begin
         tx_hold_o <= tx_data_i;
         tx_full_o <= 1'b1;
         tx_req_o  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data_o <= '0;
         rx_full_o <= 1'b0;
      end else begin
         if (rx_load_i || addr_load_i) rx_data_o <= rx_byte_i;
         if (rx_load_i)                rx_full_o <= 1'b1;
         else if (rx_rd_i)             rx_full_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           start_flag_o <= 1'b0;
      else if (start_i)     start_flag_o <= 1'b1;
      else if (start_clr_i) start_flag_o <= 1'b0;
   end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              rx_full_i,
   input  logic              tx_full_i,
   input  logic [BYTE_W-1:0] tx_hold_i,
   input  logic              tx_wr_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   output logic              matched_o,
   output logic              rx_load_o,
   output logic              addr_load_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              tx_take_o
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   tgt_state_e        st;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              byte_done;
   logic              rw_q;
   logic              nack_q;

   logic              bus_evt;
   logic              tx_avail;
   logic [BYTE_W-1:0] tx_src;
   logic              tx_due;
   logic              rx_due;
   logic              addr_hit;

   always_comb begin
      bus_evt     = start_i | stop_i;
      tx_avail    = tx_full_i | tx_wr_i;
      tx_src      = tx_full_i ? tx_hold_i : tx_data_i;
      addr_hit    = (shreg[BYTE_W-1:1] == own_addr_i);
      tx_due      = !bus_evt &&
                    ((st == ST_ADDR_ACK && scl_fall_i && rw_q) ||
                     (st == ST_TX_ACK && scl_fall_i && !nack_q) ||
                     (st == ST_TX_STALL));
      rx_due      = !bus_evt &&
                    ((st == ST_RX && scl_fall_i && byte_done) ||
                     (st == ST_RX_STALL));
      tx_take_o   = tx_due && tx_avail;
      rx_load_o   = rx_due && !rx_full_i;
      addr_load_o = !bus_evt && st == ST_ADDR && scl_fall_i && byte_done;
      rx_byte_o   = shreg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_done <= 1'b0;
         rw_q      <= 1'b0;
         nack_q    <= 1'b0;
         matched_o <= 1'b0;
         scl_oe_o  <= 1'b0;
         sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
         st        <= ST_IDLE;
         matched_o <= 1'b0;
         byte_done <= 1'b0;
         scl_oe_o  <= 1'b0;
         sda_oe_o  <= 1'b0;
      end else if (start_i) begin
         st        <= ST_ADDR;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         scl_oe_o  <= 1'b0;
         sda_oe_o  <= 1'b0;
      end else begin
         case (st)
            ST_ADDR, ST_RX: begin
               if (scl_rise_i && !byte_done) begin
                  shreg <= {shreg[BYTE_W-2:0], sda_s_i};
                  if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
                  else                     bit_cnt   <= bit_cnt + 1'b1;
               end else if (scl_fall_i && byte_done) begin
                  byte_done <= 1'b0;
                  bit_cnt   <= '0;
                  if (st == ST_ADDR) begin
                     if (addr_hit) begin
                        matched_o <= 1'b1;
                        rw_q      <= shreg[0];
                        sda_oe_o  <= 1'b1;
                        st        <= ST_ADDR_ACK;
                     end else begin
                        matched_o <= 1'b0;
                        st        <= ST_IGNORE;
                     end
                  end else if (!rx_full_i) begin
                     sda_oe_o <= 1'b1;
                     st       <= ST_RX_ACK;
                  end else begin
                     scl_oe_o <= 1'b1;
                     st       <= ST_RX_STALL;
                  end
               end
            end
            ST_RX_STALL: begin
               if (!rx_full_i) begin
                  sda_oe_o <= 1'b1;
                  scl_oe_o <= 1'b0;
                  st       <= ST_RX_ACK;
               end
            end
            ST_RX_ACK: begin
               if (scl_fall_i) begin
                  sda_oe_o <= 1'b0;
                  bit_cnt  <= '0;
                  st       <= ST_RX;
               end
            end
            ST_ADDR_ACK, ST_TX_ACK, ST_TX_STALL: begin
               if (st == ST_TX_ACK && scl_rise_i) nack_q <= sda_s_i;
               if (tx_due) begin
                  bit_cnt <= '0;
                  if (tx_avail) begin
                     shreg    <= tx_src;
                     sda_oe_o <= ~tx_src[BYTE_W-1];
                     scl_oe_o <= 1'b0;
                     st       <= ST_TX;
                  end else begin
                     sda_oe_o <= 1'b0;
                     scl_oe_o <= 1'b1;
                     st       <= ST_TX_STALL;
                  end
               end else if (scl_fall_i && st != ST_TX_STALL) begin
                  // write direction after address, or master NACK after a byte
                  sda_oe_o <= 1'b0;
                  st       <= (st == ST_ADDR_ACK) ? ST_RX : ST_IGNORE;
               end
            end
            ST_TX: begin
               if (scl_fall_i) begin
                  if (bit_cnt == LAST_BIT) begin
                     sda_oe_o <= 1'b0;
                     st       <= ST_TX_ACK;
                  end else begin
                     bit_cnt  <= bit_cnt + 1'b1;
                     shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                     sda_oe_o <= ~shreg[BYTE_W-2];
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              tx_wr_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   input  logic              rx_rd_i,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic              rx_full_o,
   output logic              tx_req_o,
   output logic              matched_o,
   output logic              start_flag_o,
   input  logic              start_clr_i
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BYTE_W != ADDR_W + 1) begin : g_bad_width
      $error("address plus direction bit must fill one byte");
   end

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              rx_load;
   logic              addr_load;
   logic              tx_take;
   logic              tx_full;
   logic [BYTE_W-1:0] tx_hold;
   logic [BYTE_W-1:0] rx_byte;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_s_o    (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   i2c_tgt_engine u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .sda_s_i     (sda_s),
      .scl_rise_i  (scl_rise),
      .scl_fall_i  (scl_fall),
      .start_i     (start_det),
      .stop_i      (stop_det),
      .own_addr_i  (own_addr_i),
      .rx_full_i   (rx_full_o),
      .tx_full_i   (tx_full),
      .tx_hold_i   (tx_hold),
      .tx_wr_i     (tx_wr_i),
      .tx_data_i   (tx_data_i),
      .scl_oe_o    (scl_oe_o),
      .sda_oe_o    (sda_oe_o),
      .matched_o   (matched_o),
      .rx_load_o   (rx_load),
      .addr_load_o (addr_load),
      .rx_byte_o   (rx_byte),
      .tx_take_o   (tx_take)
   );

   i2c_tgt_hostbuf u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_wr_i      (tx_wr_i),
      .tx_data_i    (tx_data_i),
      .tx_take_i    (tx_take),
      .tx_hold_o    (tx_hold),
      .tx_full_o    (tx_full),
      .tx_req_o     (tx_req_o),
      .rx_rd_i      (rx_rd_i),
      .rx_load_i    (rx_load),
      .addr_load_i  (addr_load),
      .rx_byte_i    (rx_byte),
      .rx_data_o    (rx_data_o),
      .rx_full_o    (rx_full_o),
      .start_i      (start_det),
      .start_clr_i  (start_clr_i),
      .start_flag_o (start_flag_o)
   );
endmodule

// File: rtl/i2c_tgt_stretch_chk.sv
module i2c_tgt_stretch_chk (
   input logic clk,
   input logic rst_n,
   input logic start_det,
   input logic stop_det,
   input logic rx_load,
   input logic tx_take,
   input logic tx_wr_i,
   input logic rx_rd_i,
   input logic rx_full_o,
   input logic tx_req_o,
   input logic matched_o,
   input logic start_flag_o,
   input logic scl_oe_o,
   input logic sda_oe_o
);
   p_start_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> start_flag_o);

   p_rx_flag_from_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full_o) |-> $past(rx_load));

   p_rx_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd_i && rx_full_o) |=> !rx_full_o);

   p_take_raises_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |=> tx_req_o);

   p_write_clears_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr_i && !tx_take) |=> !tx_req_o);

   p_stop_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!matched_o && !scl_oe_o && !sda_oe_o));
endmodule

bind i2c_tgt_stretch i2c_tgt_stretch_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_det    (start_det),
   .stop_det     (stop_det),
   .rx_load      (rx_load),
   .tx_take      (tx_take),
   .tx_wr_i      (tx_wr_i),
   .rx_rd_i      (rx_rd_i),
   .rx_full_o    (rx_full_o),
   .tx_req_o     (tx_req_o),
   .matched_o    (matched_o),
   .start_flag_o (start_flag_o),
   .scl_oe_o     (scl_oe_o),
   .sda_oe_o     (sda_oe_o)
);

// File: tb/i2c_tgt_stretch_tb_top.sv
module i2c_tgt_stretch_tb_top;
   localparam int          Q   = 10;
   localparam logic [6:0]  OWN = 7'h3C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl_lo = 1'b0;
   logic       m_sda_lo = 1'b0;
   logic       scl_oe, sda_oe;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       rx_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, tx_req, matched, start_flag;
   logic       start_clr = 1'b0;
   logic       scl_line, sda_line;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   assign scl_line = ~(m_scl_lo | scl_oe);
   assign sda_line = ~(m_sda_lo | sda_oe);

   i2c_tgt_stretch dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_line),
      .sda_i        (sda_line),
      .scl_oe_o     (scl_oe),
      .sda_oe_o     (sda_oe),
      .own_addr_i   (OWN),
      .tx_wr_i      (tx_wr),
      .tx_data_i    (tx_data),
      .rx_rd_i      (rx_rd),
      .rx_data_o    (rx_data),
      .rx_full_o    (rx_full),
      .tx_req_o     (tx_req),
      .matched_o    (matched),
      .start_flag_o (start_flag),
      .start_clr_i  (start_clr)
   );

   function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
      return {a, rw};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_high();
      while (scl_line !== 1'b1) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda_lo = 1'b0; m_scl_lo = 1'b0;
      wait_high(); tick(Q);
      m_sda_lo = 1'b1; tick(Q);
      m_scl_lo = 1'b1; tick(Q);
   endtask

   task automatic m_stop();
      m_sda_lo = 1'b1; tick(Q);
      m_scl_lo = 1'b0; wait_high(); tick(Q);
      m_sda_lo = 1'b0; tick(Q);
   endtask

   task automatic m_wbit(input logic b);
      m_sda_lo = ~b; tick(Q);
      m_scl_lo = 1'b0; wait_high(); tick(Q);
      m_scl_lo = 1'b1; tick(Q);
   endtask

   task automatic m_rbit(output logic b);
      m_sda_lo = 1'b0; tick(Q);
      m_scl_lo = 1'b0; wait_high(); tick(Q);
      b = sda_line;
      m_scl_lo = 1'b1; tick(Q);
   endtask

   task automatic m_wbits(input logic [7:0] d);
      for (int i = 7; i >= 0; i--) m_wbit(d[i]);
   endtask

   task automatic m_rbits(output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         m_rbit(b);
         d[i] = b;
      end
   endtask

   task automatic m_wbyte(input logic [7:0] d, output logic ack);
      m_wbits(d);
      m_rbit(ack);
   endtask

   task automatic host_wr(input logic [7:0] d);
      @(negedge clk); tx_wr = 1'b1; tx_data = d;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic host_rd();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog run did not finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic       ack;
      logic [7:0] d, d1, d2, r;
      int         seed;
      seed = $urandom(32'd2024);

      tick(5); rst_n = 1'b1; tick(5);
      // R1: reset state
      chk("R1", "scl_oe", scl_oe, 0);
      chk("R1", "sda_oe", sda_oe, 0);
      chk("R1", "flags", {rx_full, tx_req, matched, start_flag}, 0);
      chk("R1", "rx_data", rx_data, 8'h00);

      // R2: START flag set and cleared
      m_start();
      chk("R2", "start_flag set", start_flag, 1);
      @(negedge clk); start_clr = 1'b1; @(negedge clk); start_clr = 1'b0; tick(1);
      chk("R2", "start_flag cleared", start_flag, 0);

      // R3: matching write address
      m_wbyte(addr_byte(OWN, 1'b0), ack);
      chk("R3", "addr ack", ack, 0);
      chk("R3", "matched", matched, 1);
      chk("R3", "rx shows address", rx_data, addr_byte(OWN, 1'b0));
      chk("R3", "rx flag untouched", rx_full, 0);

      // R5: random data bytes, read between them
      for (int k = 0; k < 6; k++) begin
         d = 8'($urandom());
         m_wbyte(d, ack);
         chk("R5", "data ack", ack, 0);
         chk("R5", "rx data", rx_data, d);
         chk("R5", "rx flag set", rx_full, 1);
         host_rd(); tick(2);
         chk("R5", "rx flag cleared", rx_full, 0);
      end

      // R6: unread byte stalls the next one
      d1 = 8'hC3; d2 = 8'h5E;
      m_wbyte(d1, ack);
      chk("R6", "first ack", ack, 0);
      m_wbits(d2);
      fork
         m_rbit(ack);
         begin
            tick(60);
            chk("R6", "scl held low", scl_line, 0);
            chk("R6", "old byte kept", rx_data, d1);
            host_rd(); tick(3);
            chk("R6", "pending loaded", rx_data, d2);
            chk("R6", "flag set again", rx_full, 1);
         end
      join
      chk("R6", "stalled byte ack", ack, 0);
      host_rd();

      // R11: stop clears match
      m_stop(); tick(2);
      chk("R11", "matched cleared", matched, 0);
      chk("R11", "lines released", {scl_oe, sda_oe}, 0);

      // R4: foreign address ignored
      m_start();
      m_wbyte(addr_byte(7'h21, 1'b0), ack);
      chk("R4", "no addr ack", ack, 1);
      chk("R4", "not matched", matched, 0);
      chk("R3", "rx shows foreign address", rx_data, addr_byte(7'h21, 1'b0));
      m_wbyte(8'h00, ack);
      chk("R4", "no data ack", ack, 1);
      chk("R4", "rx unchanged", rx_data, addr_byte(7'h21, 1'b0));
      chk("R4", "rx flag unchanged", rx_full, 0);
      m_stop();

      // R7: matched read sends the held byte
      host_wr(8'hA6); tick(1);
      chk("R8", "write clears req", tx_req, 0);
      m_start(); start_clr = 1'b1; tick(1); start_clr = 1'b0;
      m_wbyte(addr_byte(OWN, 1'b1), ack);
      chk("R3", "read addr ack", ack, 0);
      chk("R8", "req after copy", tx_req, 1);
      m_rbits(d);
      chk("R7", "first tx byte", d, 8'hA6);

      // R9: empty buffer stalls after master ACK
      m_wbit(1'b0);
      fork
         m_rbits(d1);
         begin
            tick(60);
            chk("R9", "scl held low", scl_line, 0);
            host_wr(8'h3B); tick(2);
            chk("R8", "req after bypass write", tx_req, 1);
         end
      join
      chk("R9", "stalled tx byte", d1, 8'h3B);

      // R8: random bytes prepared before master ACK
      for (int k = 0; k < 6; k++) begin
         r = 8'($urandom());
         host_wr(r); tick(1);
         chk("R8", "req cleared", tx_req, 0);
         m_wbit(1'b0);
         m_rbits(d2);
         chk("R8", "next tx byte", d2, r);
      end

      // R10: NACK with a zero byte pending
      host_wr(8'h00);
      m_wbit(1'b1);
      m_rbits(d);
      chk("R10", "sda released after nack", d, 8'hFF);
      chk("R10", "sda_oe", sda_oe, 0);
      m_stop(); tick(2);
      chk("R11", "matched cleared after read", matched, 0);
      chk("R11", "lines released after read", {scl_oe, sda_oe}, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule